// File: doc/BRIEF.md
# Peripheral Request Router

This block connects a large set of peripheral DMA request lines to a smaller set of DMA channels. Every request line owns an 8-bit routing entry. The entry names one target channel and carries an enable flag. Software programs each entry through a word-addressed register window. The block decodes that window itself. The entries sit in two separate address ranges: a low range for the first 64 lines and a high range for the rest.

For each channel, the block selects the level of the request line that is routed to it. The level is registered and presented as the channel's active-request signal. The block also produces two one-cycle events per channel. A rise event marks a request appearing on a channel that was idle. The channel engine uses it to set its request-after-stopped status. A fall event marks an active request going away. The channel engine uses it to set its end-of-request status. The channel engines and the interrupt logic sit outside this block.

Top module: `dma_req_router`

## Requirements
- R1: After reset, every routing entry reads 0, and `ch_active`, `ch_rise` and `ch_fall` are all 0.
- R2: A write with `bus_we` high to address 0x100 + 4·i (i from 0 to 63) stores `bus_wdata` as the whole entry of request i. While that address is applied, `bus_rdata` returns the stored byte.
- R3: Request i from 64 to 74 uses address 0x1100 + 4·(i−64) in the same way as R2.
- R4: An address that is not word aligned, or that lies outside both ranges, gives `bus_hit` = 0 and `bus_rdata` = 0. A write to such an address changes no entry.
- R5: In an entry, bits 4:0 hold the target channel and bit 7 is the enable. A request whose entry has bit 7 clear has no effect on any channel.
- R6: `ch_active[c]` equals the level, at the previous clock edge, of the request line selected for channel c. It is 0 when no line is selected.
- R7: When the level of channel c goes from 0 to 1, `ch_rise[c]` is high for exactly one cycle, in the same cycle that `ch_active[c]` first reads 1.
- R8: When the level of channel c goes from 1 to 0, `ch_fall[c]` is high for exactly one cycle, in the same cycle that `ch_active[c]` first reads 0.
- R9: When several enabled entries name the same channel, only the lowest-numbered request drives that channel. This holds even when that request is low and a higher-numbered one is high.
- R10: An entry that names a channel number of NUM_CH or above is stored and reads back as written, but it never asserts any channel.
- R11: Rewriting an entry makes the channel level follow the newly routed request from the cycle after the write. Any level change caused this way raises the R7 and R8 events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | ADDR_W (16) | Byte address within the window |
| bus_wdata | input | 8 | Entry value to write |
| bus_rdata | output | 8 | Entry at `bus_addr`, 0 when no entry is decoded |
| bus_hit | output | 1 | `bus_addr` decodes to a routing entry |
| req_in | input | NUM_REQ (75) | Peripheral request levels |
| ch_active | output | NUM_CH (16) | Registered request level per channel |
| ch_rise | output | NUM_CH (16) | One-cycle event: request appeared on an idle channel |
| ch_fall | output | NUM_CH (16) | One-cycle event: end of request |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that `bus_we`, `bus_addr` and `bus_wdata` are stable around each rising edge, because the write check compares the stored entry with the data applied at the previous edge. The bench changes every input on the falling edge and holds reset for four cycles. The random phase mixes exact entry addresses with arbitrary 16-bit addresses and arbitrary bytes, including disabled entries and out-of-range channel numbers. The directed cases cover shared channels, disabled entries and channels beyond the configured count.

// File: rtl/drr_pkg.sv
// Shared types and field positions of a routing entry.
// Assumes the channel field is 5 bits wide, so at most 32 channels exist.
package drr_pkg;
    localparam int MAP_W     = 8;
    localparam int CH_W      = 5;
    localparam int VALID_POS = 7;

    typedef logic [MAP_W-1:0] map_t;
    typedef logic [CH_W-1:0]  chan_t;
endpackage

// File: rtl/drr_addr_decode.sv
// Decodes a byte address into a routing-entry index.
// Entries [0, LO_N) sit at LO_BASE + 4*i. Entries [LO_N, NUM_REQ) sit at
// HI_BASE + 4*(i-LO_N). Assumes the two ranges do not overlap and NUM_REQ >= 2.
module drr_addr_decode #(
    parameter int NUM_REQ  = 75,
    parameter int ADDR_W   = 16,
    parameter int LO_BASE  = 'h100,
    parameter int HI_BASE  = 'h1100,
    parameter int LO_SLOTS = 64,
    localparam int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int LO_N = (NUM_REQ < LO_SLOTS) ? NUM_REQ : LO_SLOTS;
    localparam int HI_N = NUM_REQ - LO_N;
    localparam logic [31:0] LO_START = 32'(LO_BASE);
    localparam logic [31:0] LO_END   = 32'(LO_BASE + 4 * LO_N);
    localparam logic [31:0] HI_START = 32'(HI_BASE);
    localparam logic [31:0] HI_END   = 32'(HI_BASE + 4 * HI_N);
    localparam logic [31:0] LO_N32   = 32'(LO_N);

    logic [31:0]      a32;
    logic             lo_in;
    logic             hi_in;
    logic [IDX_W-1:0] lo_idx;
    logic [IDX_W-1:0] hi_idx;

    assign a32 = {{(32-ADDR_W){1'b0}}, addr_i};

    // Low range match and index.
    always_comb begin
        lo_in  = (a32 >= LO_START) && (a32 < LO_END) && (addr_i[1:0] == 2'b00);
        lo_idx = IDX_W'((a32 - LO_START) >> 2);
    end

    // High range exists only when more requests exist than low slots.
    generate
        if (HI_N > 0) begin : g_hi
            // High range match and index.
            always_comb begin
                hi_in  = (a32 >= HI_START) && (a32 < HI_END) && (addr_i[1:0] == 2'b00);
                hi_idx = IDX_W'(((a32 - HI_START) >> 2) + LO_N32);
            end
        end else begin : g_no_hi
            assign hi_in  = 1'b0;
            assign hi_idx = '0;
        end
    endgenerate

    // Merge both ranges into one result.
    always_comb begin
        hit_o = lo_in | hi_in;
        idx_o = lo_in ? lo_idx : (hi_in ? hi_idx : '0);
    end
endmodule

// File: rtl/drr_map_regs.sv
// Storage for the routing entries: one byte per request, write port and read mux.
// Exposes the enable flag and channel field of every entry.
// Assumes wr_en is asserted only with an index that the decoder produced.
module drr_map_regs
    import drr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  map_t                          wr_data,
    input  logic [IDX_W-1:0]              rd_idx,
    output map_t                          rd_data,
    output logic [NUM_REQ-1:0]            valid_o,
    output logic [NUM_REQ-1:0][CH_W-1:0]  chan_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

    map_t q [NUM_REQ];

    generate
        for (genvar i = 0; i < NUM_REQ; i++) begin : g_entry
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
            // Load the entry when the write index selects it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q[i] <= '0;
                end else if (wr_en && (wr_idx == MY_IDX)) begin
                    q[i] <= wr_data;
                end
            end
            assign valid_o[i] = q[i][VALID_POS];
            assign chan_o[i]  = q[i][CH_W-1:0];
        end
    endgenerate

    // Read mux, zero for indices beyond the table.
    always_comb begin
        rd_data = (rd_idx <= LAST_IDX) ? q[rd_idx] : '0;
    end

    // R2 / R3: a write lands in the addressed entry.
    assert_map_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx <= LAST_IDX)) |=> (q[$past(wr_idx)] == $past(wr_data)));

    // R4: without a write, no entry field changes.
    assert_map_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(valid_o) && $stable(chan_o)));
endmodule

// File: rtl/drr_channel_select.sv
// For every channel, picks the level of the lowest-numbered enabled request
// whose entry names that channel. Channels outside [0, NUM_CH) have no
// selector, so entries that name them never reach any output.
// Assumes NUM_CH <= 32.
module drr_channel_select
    import drr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic [NUM_REQ-1:0]            valid_i,
    input  logic [NUM_REQ-1:0][CH_W-1:0]  chan_i,
    input  logic [NUM_REQ-1:0]            req_i,
    output logic [NUM_CH-1:0]             lvl_o
);
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam chan_t CH_ID = CH_W'(c);
            logic taken;
            logic lvl;
            // Priority scan from request 0 upward; the first match decides.
            always_comb begin
                taken = 1'b0;
                lvl   = 1'b0;
                for (int r = 0; r < NUM_REQ; r++) begin
                    if (!taken && valid_i[r] && (chan_i[r] == CH_ID)) begin
                        lvl   = req_i[r];
                        taken = 1'b1;
                    end
                end
            end
            assign lvl_o[c] = lvl;
        end
    endgenerate
endmodule

// File: rtl/drr_edge_track.sv
// Registers each channel's selected level and derives one-cycle rise and
// fall events from the previous registered level.
// Assumes the level inputs settle within one cycle.
module drr_edge_track #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lvl_i,
    output logic [NUM_CH-1:0] act_o,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);
    // Capture the level and compare it against the stored one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o  <= '0;
            rise_o <= '0;
            fall_o <= '0;
        end else begin
            act_o  <= lvl_i;
            rise_o <= lvl_i & ~act_o;
            fall_o <= ~lvl_i & act_o;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            // R7: a rise event coincides with a fresh 0 -> 1 of the level.
            assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[c] |-> (act_o[c] && !$past(act_o[c])));
            // R7: a rise event lasts one cycle.
            assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[c] |=> !rise_o[c]);
            // R8: a fall event coincides with a fresh 1 -> 0 of the level.
            assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
                fall_o[c] |-> (!act_o[c] && $past(act_o[c])));
            // R8: a fall event lasts one cycle.
            assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
                fall_o[c] |=> !fall_o[c]);
        end
    endgenerate
endmodule

// File: rtl/dma_req_router.sv
// Top of the request router: register window decode, routing entries,
// per-channel priority select and edge tracking.
// Assumes NUM_CH <= 32 and that the bus inputs are stable around each clock edge.
module dma_req_router
    import drr_pkg::*;
#(
    parameter int NUM_REQ  = 75,
    parameter int NUM_CH   = 16,
    parameter int ADDR_W   = 16,
    parameter int LO_BASE  = 'h100,
    parameter int HI_BASE  = 'h1100,
    parameter int LO_SLOTS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_hit,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_CH-1:0] ch_active,
    output logic [NUM_CH-1:0] ch_rise,
    output logic [NUM_CH-1:0] ch_fall
);
    localparam int IDX_W = $clog2(NUM_REQ);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

    logic [IDX_W-1:0]             dec_idx;
    logic                         dec_hit;
    map_t                         rd_entry;
    logic [NUM_REQ-1:0]           ent_valid;
    logic [NUM_REQ-1:0][CH_W-1:0] ent_chan;
    logic [NUM_CH-1:0]            sel_lvl;

    drr_addr_decode #(
        .NUM_REQ (NUM_REQ),
        .ADDR_W  (ADDR_W),
        .LO_BASE (LO_BASE),
        .HI_BASE (HI_BASE),
        .LO_SLOTS(LO_SLOTS)
    ) u_decode (
        .addr_i(bus_addr),
        .hit_o (dec_hit),
        .idx_o (dec_idx)
    );

    drr_map_regs #(
        .NUM_REQ(NUM_REQ)
    ) u_maps (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_we & dec_hit),
        .wr_idx (dec_idx),
        .wr_data(bus_wdata),
        .rd_idx (dec_idx),
        .rd_data(rd_entry),
        .valid_o(ent_valid),
        .chan_o (ent_chan)
    );

    drr_channel_select #(
        .NUM_REQ(NUM_REQ),
        .NUM_CH (NUM_CH)
    ) u_select (
        .valid_i(ent_valid),
        .chan_i (ent_chan),
        .req_i  (req_in),
        .lvl_o  (sel_lvl)
    );

    drr_edge_track #(
        .NUM_CH(NUM_CH)
    ) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (sel_lvl),
        .act_o (ch_active),
        .rise_o(ch_rise),
        .fall_o(ch_fall)
    );

    // Bus outputs: decoded entry or zero.
    always_comb begin
        bus_hit   = dec_hit;
        bus_rdata = dec_hit ? rd_entry : 8'h00;
    end

    // R4: only word-aligned addresses can decode to an entry.
    assert_hit_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> (bus_addr[1:0] == 2'b00));

    // R3: a decoded index never points past the last request.
    assert_hit_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> (dec_idx <= LAST_IDX));
endmodule

// File: tb/dma_req_router_bench.sv
`timescale 1ns/1ps
module dma_req_router_bench;
    localparam int NR = 75;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_hit;
    logic [NR-1:0] req_in = '0;
    logic [NC-1:0] ch_active;
    logic [NC-1:0] ch_rise;
    logic [NC-1:0] ch_fall;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [7:0]    mdl [NR];
    logic [NC-1:0] prev_lvl = '0;

    always #10 clk = ~clk;

    dma_req_router u_dma_req_router (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
        .req_in(req_in), .ch_active(ch_active), .ch_rise(ch_rise), .ch_fall(ch_fall)
    );

    function automatic logic [15:0] addr_of(int i);
        return (i < 64) ? 16'(32'h100 + 4 * i) : 16'(32'h1100 + 4 * (i - 64));
    endfunction

    function automatic int idx_of(logic [15:0] a);
        for (int i = 0; i < NR; i++) if (addr_of(i) == a) return i;
        return -1;
    endfunction

    function automatic logic [NC-1:0] exp_lvl(logic [NR-1:0] rq);
        logic [NC-1:0] v = '0;
        for (int c = 0; c < NC; c++) begin
            bit found = 0;
            for (int r = 0; r < NR; r++) begin
                if (!found && mdl[r][7] && (int'(mdl[r][4:0]) == c)) begin
                    v[c] = rq[r];
                    found = 1;
                end
            end
        end
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: apply at negedge, clock, check at the next negedge.
    task automatic step(logic we, logic [15:0] a, logic [7:0] d, logic [NR-1:0] rq);
        logic [NC-1:0] e;
        int ix;
        bus_we = we; bus_addr = a; bus_wdata = d; req_in = rq;
        e = exp_lvl(rq);
        @(posedge clk);
        ix = idx_of(a);
        if (we && ix >= 0) mdl[ix] = d;
        @(negedge clk);
        check("R6 ch_active", 32'(ch_active), 32'(e));
        check("R7 ch_rise", 32'(ch_rise), 32'(e & ~prev_lvl));
        check("R8 ch_fall", 32'(ch_fall), 32'(~e & prev_lvl));
        check("R4 bus_hit", 32'(bus_hit), 32'(ix >= 0));
        check("R2 bus_rdata", 32'(bus_rdata), (ix >= 0) ? 32'(mdl[ix]) : 32'h0);
        prev_lvl = e;
        bus_we = 1'b0;
    endtask

    task automatic rd_check(string tag, int i);
        bus_we = 1'b0; bus_addr = addr_of(i);
        #1;
        check(tag, 32'(bus_rdata), 32'(mdl[i]));
    endtask

    initial begin
        logic [NR-1:0] rq;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ch_active", 32'(ch_active), 0);
        check("R1 ch_rise", 32'(ch_rise), 0);
        check("R1 ch_fall", 32'(ch_fall), 0);
        rd_check("R1 entry0", 0);
        rd_check("R1 entry74", 74);

        // R2 / R3: low and high range writes with readback
        step(1, addr_of(5), 8'h83, '0);
        step(1, addr_of(70), 8'hE5, '0);
        rd_check("R2 entry5", 5);
        rd_check("R3 entry70", 70);

        // R4: unaligned and out-of-range writes change nothing
        step(1, 16'h0102, 8'hFF, '0);
        step(1, 16'h00FC, 8'hFF, '0);
        step(1, 16'h0200, 8'hFF, '0);
        step(1, 16'h112C, 8'hFF, '0);
        step(1, 16'h1101, 8'hFF, '0);
        for (int i = 0; i < NR; i++) rd_check("R4 entry unchanged", i);

        // R6 / R7 / R8: request 5 on channel 3, raise, hold, drop
        rq = '0; rq[5] = 1'b1;
        step(0, 16'h0, 8'h0, rq);
        check("R7 rise ch3", 32'(ch_rise[3]), 1);
        step(0, 16'h0, 8'h0, rq);
        check("R7 single pulse ch3", 32'(ch_rise[3]), 0);
        rq[5] = 1'b0;
        step(0, 16'h0, 8'h0, rq);
        check("R8 fall ch3", 32'(ch_fall[3]), 1);

        // R5: disabled entry 10 naming channel 4
        step(1, addr_of(10), 8'h04, '0);
        rq = '0; rq[10] = 1'b1;
        step(0, 16'h0, 8'h0, rq);
        check("R5 disabled ignored", 32'(ch_active[4]), 0);

        // R9: entries 20 and 60 share channel 7
        step(1, addr_of(20), 8'h87, '0);
        step(1, addr_of(60), 8'h87, '0);
        rq = '0; rq[60] = 1'b1;
        step(0, 16'h0, 8'h0, rq);
        check("R9 low-numbered low wins", 32'(ch_active[7]), 0);
        rq = '0; rq[20] = 1'b1;
        step(0, 16'h0, 8'h0, rq);
        check("R9 low-numbered high wins", 32'(ch_active[7]), 1);
        // R11: disable entry 20, channel 7 now follows request 60 (low)
        step(1, addr_of(20), 8'h07, rq);
        check("R11 old route held in write cycle", 32'(ch_active[7]), 1);
        step(0, 16'h0, 8'h0, rq);
        check("R11 fall after remap", 32'(ch_fall[7]), 1);

        // R10: entry 30 names channel 20 (beyond 16)
        step(1, addr_of(30), 8'h94, '0);
        rd_check("R10 stored", 30);
        rq = '0; rq[30] = 1'b1;
        step(0, 16'h0, 8'h0, rq);
        step(0, 16'h0, 8'h0, rq);
        check("R10 no channel", 32'(ch_active), 0);

        // Random mix
        rq = '0;
        for (int n = 0; n < 600; n++) begin
            logic we;
            logic [15:0] a;
            we = ($urandom % 3) == 0;
            if (($urandom % 4) == 0) a = 16'($urandom);
            else a = addr_of(int'($urandom % NR));
            for (int k = 0; k < 3; k++) rq[$urandom % NR] ^= 1'b1;
            step(we, a, 8'($urandom), rq);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule